// File: doc/BRIEF.md
# Dual-Symbol 8b/10b Transmit Serializer

This block turns a 20-bit parallel word holding two symbols into a serial 8b/10b bit stream. Each symbol is a control flag plus a data byte. The block encodes both symbols with 8b/10b, carries the running disparity from one code to the next, and shifts the resulting twenty code bits out one per clock. The clock is the serial clock, so one parallel word spans twenty clock cycles.

A new word is taken only at a pair boundary. The `pairLoad` output marks the cycle at whose closing edge the capture happens. When `wordValid` is low at that edge, a pair of idle commas is sent instead. Two static selects set the order of the two symbols within a pair and which end of each 10-bit code leaves the block first. A control flag set on a byte that is not a legal control character raises a sticky error flag. That symbol is then encoded as data.

Top module: `dual_sym_8b10b_tx`

## Requirements
- R1: The upper symbol has its control flag on `wordIn[18]` and its byte on `wordIn[17:10]`; the lower symbol has its flag on `wordIn[8]` and its byte on `wordIn[7:0]`. Byte bit 7 is encoded as bit H and byte bit 0 as bit A, following the standard 8b/10b code tables.
- R2: `wordIn[19]` and `wordIn[9]` have no effect on the serial output.
- R3: With `lowFirst`=0 the upper symbol's code is sent first and the lower symbol's code second; with `lowFirst`=1 the lower symbol's code goes first.
- R4: Each code is written abcdei fghj. With `aFirst`=1, bit a leaves first and bit j last; with `aFirst`=0, j leaves first and a last.
- R5: Running disparity is negative after reset. It is updated after every code in transmission order, so every 10-bit code carries 4, 5 or 6 ones.
- R6: With the control flag set, the twelve legal control characters are encoded as control codes: K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7.
- R7: A control flag on any other byte sets `badCtrl`, and that symbol is encoded as the data character of the same byte. `badCtrl` stays high until reset.
- R8: The word is sampled only at the edge that closes a cycle with `pairLoad` high. `pairLoad` is high for one cycle in every twenty. If `wordValid` is low at that edge, a K28.5 pair is sent. Input changes at any other time have no effect.
- R9: `symStrobe` is high for exactly the cycle in which the first serial bit of each code is on `serOut`. This is the cycle after the load edge and ten cycles later.
- R10: While reset is held, `serOut`, `symStrobe`, `pairLoad` and `badCtrl` are all 0. The first load happens at the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Synchronous active-low reset |
| wordIn | input | 20 | Two symbols: flag+byte at 18:10 and 8:0, bits 19 and 9 unused |
| wordValid | input | 1 | wordIn holds a word to send at the next load |
| lowFirst | input | 1 | 1: lower symbol sent first |
| aFirst | input | 1 | 1: bit a of each code sent first; 0: bit j first |
| serOut | output | 1 | Serial code bit |
| symStrobe | output | 1 | First bit of a 10-bit code is on serOut |
| pairLoad | output | 1 | The word is captured at the end of this cycle |
| badCtrl | output | 1 | Sticky: an illegal control character was requested |

## Verification
Every data byte value is swept, with all four order settings rotating through the sweep and the unused bits toggled. The bench carries the running disparity through the whole stream.
- An encoder that forgets the disparity state, or updates it in field order rather than send order, puts a wrong code on the wire at the next unbalanced symbol.
- A reversed symbol order or a reversed bit order shows up as a mismatched bit pattern.
- The twelve control characters go through both disparity states. This catches the K28 codes, whose balanced 4-bit tails must be inverted as a whole with the 6-bit part.
- An illegal control request, and a word rewritten in the middle of a frame, test that `badCtrl` latches and that the serializer ignores mid-pair input changes.

// File: rtl/tx8b10b_pkg.sv
package tx8b10b_pkg;

  localparam int CODE_BITS     = 10;
  localparam int SYMS_PER_PAIR = 2;
  localparam int PAIR_BITS     = CODE_BITS * SYMS_PER_PAIR;
  localparam int WORD_BITS     = 20;
  localparam int SYM_BITS      = 9;
  localparam int CNT_W         = $clog2(PAIR_BITS);

  // Idle pair: two K28.5 symbols, unused bits low.
  localparam logic [WORD_BITS-1:0] IDLE_WORD = {1'b0, 1'b1, 8'hBC, 1'b0, 1'b1, 8'hBC};

  typedef struct packed {
    logic k;
    logic [7:0] data;
  } symbol_t;

  typedef struct packed {
    logic loadPair;
    logic symStart;
  } txStrobes_t;

  typedef struct packed {
    logic [CODE_BITS-1:0] code;
    logic rdPos;
  } encResult_t;

  // 6-bit sub-block, written abcdei, negative-disparity column.
  function automatic logic [5:0] sixNegLit(input logic [4:0] x);
    logic [5:0] r;
    case (x)
      5'd0:  r = 6'b100111;  5'd1:  r = 6'b011101;
      5'd2:  r = 6'b101101;  5'd3:  r = 6'b110001;
      5'd4:  r = 6'b110101;  5'd5:  r = 6'b101001;
      5'd6:  r = 6'b011001;  5'd7:  r = 6'b111000;
      5'd8:  r = 6'b111001;  5'd9:  r = 6'b100101;
      5'd10: r = 6'b010101;  5'd11: r = 6'b110100;
      5'd12: r = 6'b001101;  5'd13: r = 6'b101100;
      5'd14: r = 6'b011100;  5'd15: r = 6'b010111;
      5'd16: r = 6'b011011;  5'd17: r = 6'b100011;
      5'd18: r = 6'b010011;  5'd19: r = 6'b110010;
      5'd20: r = 6'b001011;  5'd21: r = 6'b101010;
      5'd22: r = 6'b011010;  5'd23: r = 6'b111010;
      5'd24: r = 6'b110011;  5'd25: r = 6'b100110;
      5'd26: r = 6'b010110;  5'd27: r = 6'b110110;
      5'd28: r = 6'b001110;  5'd29: r = 6'b101110;
      5'd30: r = 6'b011110;  default: r = 6'b101011;
    endcase
    return r;
  endfunction

  // 4-bit sub-block, written fghj, negative-disparity column.
  function automatic logic [3:0] fourNegLit(input logic [2:0] y, input logic alt7);
    logic [3:0] r;
    case (y)
      3'd0: r = 4'b1011;
      3'd1: r = 4'b1001;
      3'd2: r = 4'b0101;
      3'd3: r = 4'b1100;
      3'd4: r = 4'b1101;
      3'd5: r = 4'b1010;
      3'd6: r = 4'b0110;
      default: r = alt7 ? 4'b0111 : 4'b1110;
    endcase
    return r;
  endfunction

  function automatic logic ctrlLegal(input logic [7:0] b);
    logic [4:0] x;
    x = b[4:0];
    return (x == 5'd28) ||
           ((b[7:5] == 3'd7) && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
  endfunction

  // Code index 0 holds bit a, index 9 holds bit j.
  function automatic logic [CODE_BITS-1:0] packCode(input logic [5:0] six, input logic [3:0] four);
    logic [CODE_BITS-1:0] c;
    for (int i = 0; i < 6; i++) c[i] = six[5-i];
    for (int i = 0; i < 4; i++) c[6+i] = four[3-i];
    return c;
  endfunction

  function automatic encResult_t encodeSym(input symbol_t s, input logic rdPos);
    encResult_t res;
    logic [4:0] x;
    logic [2:0] y;
    logic isK, k28, rdWork, rd6, sixUnbal, fourUnbal, alt7;
    logic [5:0] six;
    logic [3:0] four;
    logic [CODE_BITS-1:0] code;
    x = s.data[4:0];
    y = s.data[7:5];
    isK = s.k && ctrlLegal(s.data);
    k28 = isK && (x == 5'd28);
    // K28 codes are built for negative disparity and inverted whole when positive.
    rdWork = k28 ? 1'b0 : rdPos;
    six = k28 ? 6'b001111 : sixNegLit(x);
    sixUnbal = ($countones(six) != 3);
    if (rdWork && (sixUnbal || x == 5'd7)) six = ~six;
    rd6 = sixUnbal ? ~rdWork : rdWork;
    alt7 = (y == 3'd7) &&
           (isK ||
            (!rd6 && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
            ( rd6 && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    four = fourNegLit(y, alt7);
    fourUnbal = ($countones(four) != 2);
    if (rd6 && (fourUnbal || y == 3'd3)) four = ~four;
    code = packCode(six, four);
    if (k28 && rdPos) code = ~code;
    res.code  = code;
    res.rdPos = ($countones(code) != 5) ? ~rdPos : rdPos;
    return res;
  endfunction

endpackage

// File: rtl/tx_sym_encoder.sv
module tx_sym_encoder
  import tx8b10b_pkg::*;
(
  input  symbol_t              sym,
  input  logic                 rdIn,
  output logic [CODE_BITS-1:0] code,
  output logic                 rdOut,
  output logic                 ctrlBad
);
  encResult_t res;

  always_comb begin
    res     = encodeSym(sym, rdIn);
    code    = res.code;
    rdOut   = res.rdPos;
    ctrlBad = sym.k && !ctrlLegal(sym.data);
  end
endmodule

// File: rtl/tx_control.sv
module tx_control
  import tx8b10b_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  output txStrobes_t strobes
);
  localparam logic [CNT_W-1:0] LAST_IDX   = CNT_W'(PAIR_BITS - 1);
  localparam logic [CNT_W-1:0] SECOND_IDX = CNT_W'(CODE_BITS);

  logic [CNT_W-1:0] bitIdx;

  always_ff @(posedge clk) begin
    if (!rstN)                  bitIdx <= LAST_IDX;
    else if (bitIdx == LAST_IDX) bitIdx <= '0;
    else                        bitIdx <= bitIdx + 1'b1;
  end

  always_comb begin
    strobes.loadPair = rstN && (bitIdx == LAST_IDX);
    strobes.symStart = rstN && ((bitIdx == '0) || (bitIdx == SECOND_IDX));
  end
endmodule

// File: rtl/tx_datapath.sv
module tx_datapath
  import tx8b10b_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  txStrobes_t           strobes,
  input  logic [WORD_BITS-1:0] wordIn,
  input  logic                 wordValid,
  input  logic                 lowFirst,
  input  logic                 aFirst,
  output logic                 serOut,
  output logic                 badCtrl
);
  logic [WORD_BITS-1:0] srcWord;
  symbol_t              hiSym, loSym;
  symbol_t              syms    [SYMS_PER_PAIR];
  logic [CODE_BITS-1:0] codes   [SYMS_PER_PAIR];
  logic                 rdChain [SYMS_PER_PAIR+1];
  logic [SYMS_PER_PAIR-1:0] badVec;
  logic [PAIR_BITS-1:0] loadVec;
  logic [PAIR_BITS-1:0] shiftReg;
  logic                 rdReg;
  logic                 unusedPadBits;

  function automatic logic [CODE_BITS-1:0] orderBits(input logic [CODE_BITS-1:0] c, input logic aLead);
    logic [CODE_BITS-1:0] o;
    for (int i = 0; i < CODE_BITS; i++) o[i] = aLead ? c[i] : c[CODE_BITS-1-i];
    return o;
  endfunction

  assign srcWord       = wordValid ? wordIn : IDLE_WORD;
  assign hiSym         = symbol_t'(srcWord[18:10]);
  assign loSym         = symbol_t'(srcWord[8:0]);
  assign unusedPadBits = srcWord[19] ^ srcWord[9];
  assign syms[0]       = lowFirst ? loSym : hiSym;
  assign syms[1]       = lowFirst ? hiSym : loSym;
  assign rdChain[0]    = rdReg;

  for (genvar g = 0; g < SYMS_PER_PAIR; g++) begin : g_enc
    tx_sym_encoder u_enc (
      .sym    (syms[g]),
      .rdIn   (rdChain[g]),
      .code   (codes[g]),
      .rdOut  (rdChain[g+1]),
      .ctrlBad(badVec[g])
    );
    assign loadVec[g*CODE_BITS +: CODE_BITS] = orderBits(codes[g], aFirst);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      rdReg    <= 1'b0;
      badCtrl  <= 1'b0;
    end else if (strobes.loadPair) begin
      shiftReg <= loadVec;
      rdReg    <= rdChain[SYMS_PER_PAIR];
      if (|badVec) badCtrl <= 1'b1;
    end else begin
      shiftReg <= shiftReg >> 1;
    end
  end

  assign serOut = shiftReg[0];
endmodule

// File: rtl/dual_sym_8b10b_tx.sv
module dual_sym_8b10b_tx
  import tx8b10b_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [19:0] wordIn,
  input  logic        wordValid,
  input  logic        lowFirst,
  input  logic        aFirst,
  output logic        serOut,
  output logic        symStrobe,
  output logic        pairLoad,
  output logic        badCtrl
);
  txStrobes_t strobes;

  tx_control u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes)
  );

  tx_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wordIn   (wordIn),
    .wordValid(wordValid),
    .lowFirst (lowFirst),
    .aFirst   (aFirst),
    .serOut   (serOut),
    .badCtrl  (badCtrl)
  );

  assign symStrobe = strobes.symStart;
  assign pairLoad  = strobes.loadPair;
endmodule

// File: rtl/dual_sym_8b10b_tx_chk.sv
module dual_sym_8b10b_tx_chk (
  input logic clk,
  input logic rstN,
  input logic serOut,
  input logic symStrobe,
  input logic pairLoad,
  input logic badCtrl
);
  logic [3:0] bitCnt;
  logic [3:0] onesCnt;
  logic       primed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      onesCnt <= '0;
      primed  <= 1'b0;
    end else if (symStrobe) begin
      bitCnt  <= 4'd1;
      onesCnt <= {3'b0, serOut};
      primed  <= 1'b1;
    end else if (primed) begin
      bitCnt  <= bitCnt + 4'd1;
      onesCnt <= onesCnt + {3'b0, serOut};
    end
  end

  // R5, R9: each code spans ten bits and holds 4 to 6 ones
  assert_code_balance_R5: assert property (@(posedge clk) disable iff (!rstN)
    (symStrobe && primed) |-> (bitCnt == 4'd10 && onesCnt >= 4'd4 && onesCnt <= 4'd6));

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    symStrobe |=> !symStrobe);

  assert_load_then_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    pairLoad |=> (symStrobe && !pairLoad));

  assert_bad_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    badCtrl |=> badCtrl);
endmodule

bind dual_sym_8b10b_tx dual_sym_8b10b_tx_chk i_chk (.*);

// File: tb/test_dual_sym_8b10b_tx.sv
module test_dual_sym_8b10b_tx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [19:0] wordIn = '0;
  logic wordValid = 1'b0, lowFirst = 1'b0, aFirst = 1'b1;
  logic serOut, symStrobe, pairLoad, badCtrl;

  int checks = 0;
  int failures = 0;
  logic expRd = 1'b0;
  logic expBad = 1'b0;

  always #4 clk = ~clk;

  dual_sym_8b10b_tx i_dual_sym_8b10b_tx (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .wordValid(wordValid),
    .lowFirst(lowFirst), .aFirst(aFirst), .serOut(serOut),
    .symStrobe(symStrobe), .pairLoad(pairLoad), .badCtrl(badCtrl)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [5:0] refSix(input logic [4:0] x);
    logic [5:0] t;
    case (x)
      0: t = 6'b100111;  1: t = 6'b011101;  2: t = 6'b101101;  3: t = 6'b110001;
      4: t = 6'b110101;  5: t = 6'b101001;  6: t = 6'b011001;  7: t = 6'b111000;
      8: t = 6'b111001;  9: t = 6'b100101; 10: t = 6'b010101; 11: t = 6'b110100;
      12: t = 6'b001101; 13: t = 6'b101100; 14: t = 6'b011100; 15: t = 6'b010111;
      16: t = 6'b011011; 17: t = 6'b100011; 18: t = 6'b010011; 19: t = 6'b110010;
      20: t = 6'b001011; 21: t = 6'b101010; 22: t = 6'b011010; 23: t = 6'b111010;
      24: t = 6'b110011; 25: t = 6'b100110; 26: t = 6'b010110; 27: t = 6'b110110;
      28: t = 6'b001110; 29: t = 6'b101110; 30: t = 6'b011110; default: t = 6'b101011;
    endcase
    return t;
  endfunction

  // Reference encoder. Output code index 0 is bit a.
  task automatic refEnc(input logic k, input logic [7:0] b, input logic rdIn,
                        output logic [9:0] c, output logic rdOut, output logic bad);
    logic [4:0] x;
    logic [2:0] y;
    logic legal, kk, r, alt;
    logic [5:0] s;
    logic [3:0] f;
    logic [9:0] t;
    x = b[4:0];
    y = b[7:5];
    legal = (x == 28) || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30));
    bad = k && !legal;
    kk = k && legal;
    if (kk && x == 28) begin
      case (y)
        0: t = 10'b0011110100; 1: t = 10'b0011111001;
        2: t = 10'b0011110101; 3: t = 10'b0011110011;
        4: t = 10'b0011110010; 5: t = 10'b0011111010;
        6: t = 10'b0011110110; default: t = 10'b0011111000;
      endcase
      if (rdIn) t = ~t;
    end else begin
      s = refSix(x);
      if (rdIn && ($countones(s) != 3 || x == 7)) s = ~s;
      r = rdIn ^ ($countones(s) != 3);
      alt = (y == 7) && (kk || (!r && (x == 17 || x == 18 || x == 20)) ||
                         (r && (x == 11 || x == 13 || x == 14)));
      case (y)
        0: f = 4'b1011; 1: f = 4'b1001; 2: f = 4'b0101; 3: f = 4'b1100;
        4: f = 4'b1101; 5: f = 4'b1010; 6: f = 4'b0110;
        default: f = alt ? 4'b0111 : 4'b1110;
      endcase
      if (r && ($countones(f) != 2 || y == 3)) f = ~f;
      t = {s, f};
    end
    for (int i = 0; i < 10; i++) c[i] = t[9-i];
    rdOut = rdIn ^ ($countones(t) != 5);
  endtask

  // Entered at a falling edge where pairLoad is high; returns at the next such edge.
  task automatic runFrame(input logic [19:0] w, input logic v, input logic lf,
                          input logic af, input bit midChange, input string tag);
    logic [19:0] src, expBits, got, strb, loads;
    logic [8:0] symA, symB;
    logic [9:0] c;
    logic rdN, bad;
    wordIn = w; wordValid = v; lowFirst = lf; aFirst = af;
    src = v ? w : {1'b0, 1'b1, 8'hBC, 1'b0, 1'b1, 8'hBC};
    symA = lf ? src[8:0] : src[18:10];
    symB = lf ? src[18:10] : src[8:0];
    for (int j = 0; j < 2; j++) begin
      refEnc(j == 0 ? symA[8] : symB[8], j == 0 ? symA[7:0] : symB[7:0], expRd, c, rdN, bad);
      expRd = rdN;
      if (bad) expBad = 1'b1;
      for (int i = 0; i < 10; i++) expBits[j*10+i] = af ? c[i] : c[9-i];
    end
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      got[i] = serOut;
      strb[i] = symStrobe;
      loads[i] = pairLoad;
      if (midChange && i == 4) begin
        wordIn = ~w; wordValid = ~v; lowFirst = ~lf; aFirst = ~af;
      end
    end
    chk(got == expBits, tag, "serial bits", {12'b0, got}, {12'b0, expBits});
    chk(strb == 20'h00401, "R9", "symStrobe pattern", {12'b0, strb}, 32'h00401);
    chk(loads == 20'h80000, "R8", "pairLoad pattern", {12'b0, loads}, 32'h80000);
    chk(badCtrl == expBad, "R7", "badCtrl", {31'b0, badCtrl}, {31'b0, expBad});
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R10: quiet outputs under reset
    chk({serOut, symStrobe, pairLoad, badCtrl} == 4'b0, "R10", "outputs in reset",
        {28'b0, serOut, symStrobe, pairLoad, badCtrl}, 32'h0);
    rstN = 1'b1;
    expRd = 1'b0;
    expBad = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  logic [7:0] kList [12];

  initial begin
    kList[0] = 8'h1C; kList[1] = 8'h3C; kList[2]  = 8'h5C; kList[3]  = 8'h7C;
    kList[4] = 8'h9C; kList[5] = 8'hBC; kList[6]  = 8'hDC; kList[7]  = 8'hFC;
    kList[8] = 8'hF7; kList[9] = 8'hFB; kList[10] = 8'hFD; kList[11] = 8'hFE;

    doReset();
    // R1, R2, R3, R4, R5: every byte as data, all orders, unused bits toggled
    for (int n = 0; n < 128; n++) begin
      logic [7:0] hi, lo;
      logic [3:0] nb;
      hi = 8'(2 * n);
      lo = 8'(2 * n + 1);
      nb = 4'(n);
      runFrame({nb[2], 1'b0, hi, nb[3], 1'b0, lo}, 1'b1, nb[0], nb[1], 1'b0, "R1/R2/R3/R4/R5");
    end
    // R6: legal control characters, repeated so both disparities occur
    for (int r = 0; r < 2; r++) begin
      for (int n = 0; n < 12; n++) begin
        logic [1:0] o;
        o = 2'(n + r);
        runFrame({2'b01, kList[n], 2'b00, 8'h00}, 1'b1, o[0], o[1], 1'b0, "R6");
        runFrame({2'b01, kList[n], 2'b01, kList[(n+5)%12]}, 1'b1, o[1], o[0], 1'b0, "R6/R5");
      end
    end
    // R8: idle pairs and a word rewritten mid-frame
    runFrame(20'h12345, 1'b0, 1'b0, 1'b1, 1'b0, "R8 idle");
    runFrame(20'h0ABCD, 1'b0, 1'b1, 1'b0, 1'b0, "R8 idle");
    runFrame({2'b00, 8'h3A, 2'b00, 8'h5F}, 1'b1, 1'b0, 1'b1, 1'b1, "R8 midchange");
    runFrame({2'b00, 8'h17, 2'b00, 8'hE4}, 1'b1, 1'b1, 1'b0, 1'b1, "R8 midchange");
    // R7: illegal control request encodes as data and latches the flag
    runFrame({2'b01, 8'h00, 2'b00, 8'h95}, 1'b1, 1'b0, 1'b1, 1'b0, "R7 illegal K");
    runFrame({2'b00, 8'h44, 2'b01, 8'hBC}, 1'b1, 1'b1, 1'b1, 1'b0, "R7 sticky");
    runFrame({2'b00, 8'h77, 2'b01, 8'hFD}, 1'b1, 1'b0, 1'b0, 1'b0, "R7 sticky");
    // R10: reset clears the flag and restores negative disparity
    doReset();
    runFrame({2'b01, 8'hBC, 2'b00, 8'h0B}, 1'b1, 1'b0, 1'b1, 1'b0, "R10/R5");
    runFrame({2'b00, 8'h07, 2'b00, 8'h2D}, 1'b1, 1'b1, 1'b1, 1'b0, "R10/R5");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule